// File: doc/BRIEF.md
# Multi-mode video palette register file

This block holds the colour palettes of a display controller and lets a CPU write and read them through four byte-wide ports. One port carries either a palette index or a packed digital colour byte. The other three ports carry the green, red and blue components. A two-bit mode input decides how these ports are read. In packed digital mode, four 8-colour palette bytes are written directly. In 16-entry analog mode, each entry has three 4-bit components. In 256-entry analog mode, each entry has three byte components.

Every write that changes the visible palette produces a one-cycle `redraw` pulse for the display pipeline. A reset, or a request to restore defaults, starts an internal fill sequencer. The sequencer reloads all three palettes with their default contents, one 256-colour entry per clock, and holds `busy` high while it runs. Pixel lookup and DAC output belong to other blocks.

Top module: `pal_regfile`

## Requirements
- R1: A cycle with `rst` high, or a cycle with `init_req` high while `busy` is low, starts a fill. `busy` is high in the cycle after that edge and stays high for exactly 256 clock edges. `redraw` is high for one cycle in the same cycle that `busy` falls. `init_req` has no effect while `busy` is high.
- R2: While `busy` is high, CPU writes change no palette entry, change no index and raise no `redraw`. A write in the same cycle that a fill starts is also dropped.
- R3: Mode priority: `mode[1]`=1 selects 256-entry analog, whatever `mode[0]` is. Otherwise `mode[0]`=1 selects 16-entry analog. `mode`=0 selects packed digital. The same priority applies to writes and to reads.
- R4: Port select 0 is the index port. In either analog mode, a write to it latches the full 8-bit palette number and raises no `redraw`. A read of it returns that number.
- R5: Port select 1, 2 and 3 are green, red and blue. In digital mode, port select 0, 1, 2 and 3 address packed entries 3, 1, 2 and 0. A write stores the whole byte, and a read returns it.
- R6: A digital write raises `redraw` only when the new byte differs from the stored one in bits 6:4 or 2:0 (mask 0x77). Differences only in bit 7 or bit 3 raise nothing.
- R7: In 16-entry mode, a colour write stores the low 4 bits of the data into the component of entry index[3:0]. Green, red and blue are component slots 0, 1 and 2. A read returns the component zero-extended. Every colour write raises `redraw`.
- R8: In 256-entry mode, a colour write stores the full byte into the component of entry index[7:0]. This store is separate from the 16-entry store. Every colour write raises `redraw`.
- R9: `rd_valid` is high exactly two cycles after a cycle with `rd_en` high. `rd_data` then holds the value the port had before any write in that same read cycle.
- R10: The default digital entries 0..3 are 0x04, 0x15, 0x26 and 0x37.
- R11: The default 16 entries come from the 12-bit words 000, 007, 070, 077, 700, 707, 770, 777, 444, 00f, 0f0, 0ff, f00, f0f, ff0, fff. In each word, green is bits 11:8, red is bits 7:4 and blue is bits 3:0.
- R12: The default 256 entry n is built from base b = n with its low 3 bits cleared and k = n mod 8. When k=0, all three components are the grey level b-4, or 0 when b=0. Otherwise each component is b+7 when its bit of k is set and 0 when it is clear. Green uses bit 2 of k, red uses bit 1 and blue uses bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also starts a fill |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| port_sel | input | 2 | 0 index/packed, 1 green, 2 red, 3 blue |
| wr_data | input | 8 | Write data |
| mode | input | 2 | bit1 256-entry analog, bit0 16-entry analog |
| init_req | input | 1 | Request to reload all defaults |
| rd_data | output | 8 | Read data |
| rd_valid | output | 1 | Read data valid |
| redraw | output | 1 | One-cycle palette-changed pulse |
| busy | output | 1 | Default fill in progress |

## Verification
The hardest situations to reach from the ports are collisions in time: a write during a running fill, a write in the same cycle as a read of the same port, and a digital write whose difference lies only in the masked bits 7 and 3. The stimulus raises `init_req` and then writes while `busy` is still high. It drives both strobes on the same edge. It also steps a single digital entry through values that differ first in masked bits and then in unmasked bits. A behavioural model built from integer arrays runs alongside every clock and checks `busy`, `redraw` and every returned read.

// File: rtl/pal_pkg.sv
package pal_pkg;

  typedef enum logic [1:0] {
    PORT_INDEX = 2'd0,
    PORT_GRN   = 2'd1,
    PORT_RED   = 2'd2,
    PORT_BLU   = 2'd3
  } pal_port_e;

  // component slot: 0 green, 1 red, 2 blue
  function automatic logic pick_bit(input logic [2:0] k, input logic [1:0] c);
    case (c)
      2'd0:    return k[2];
      2'd1:    return k[1];
      default: return k[0];
    endcase
  endfunction

  // packed digital default for entry e
  function automatic logic [7:0] dig_dflt(input logic [1:0] e);
    return {2'b00, e, 2'b01, e};
  endfunction

  // port select to packed digital entry
  function automatic logic [1:0] dig_entry(input logic [1:0] s);
    case (s)
      2'd0:    return 2'd3;
      2'd1:    return 2'd1;
      2'd2:    return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

  // 16-entry default component
  function automatic logic [3:0] small_dflt(input logic [3:0] e, input logic [1:0] c);
    logic b;
    b = pick_bit(e[2:0], c);
    if (e == 4'd8) return 4'd4;
    if (e[3])      return b ? 4'hF : 4'h0;
    return b ? 4'h7 : 4'h0;
  endfunction

  // 256-entry default component
  function automatic logic [7:0] big_dflt(input logic [7:0] n, input logic [1:0] c);
    logic [7:0] base;
    base = {n[7:3], 3'b000};
    if (n[2:0] == 3'd0) return (base == 8'd0) ? 8'd0 : base - 8'd4;
    return pick_bit(n[2:0], c) ? base + 8'd7 : 8'd0;
  endfunction

endpackage

// File: rtl/pal_init_seq.sv
module pal_init_seq #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  output logic          busy,
  output logic          launch,
  output logic          last,
  output logic [AW-1:0] addr
);

  assign launch = rst | (req & ~busy);
  assign last   = busy & (addr == AW'(DEPTH - 1));

  always_ff @(posedge clk) begin
    if (launch) begin
      busy <= 1'b1;
      addr <= '0;
    end else if (busy) begin
      if (last) busy <= 1'b0;
      addr <= addr + 1'b1;
    end
  end

endmodule

// File: rtl/pal_bank.sv
module pal_bank #(
  parameter int DEPTH = 256,
  parameter int CW    = 8,
  parameter int NCOMP = 3,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic [NCOMP-1:0]    we,
  input  logic [AW-1:0]       waddr,
  input  logic [NCOMP*CW-1:0] wdata,
  input  logic [AW-1:0]       raddr,
  output logic [NCOMP*CW-1:0] rdata
);

  // one simple dual-port array per component
  for (genvar c = 0; c < NCOMP; c++) begin : g_comp
    logic [CW-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we[c]) mem[waddr] <= wdata[c*CW +: CW];
      rdata[c*CW +: CW] <= mem[raddr];
    end
  end

endmodule

// File: rtl/pal_digital.sv
module pal_digital
  import pal_pkg::*;
#(
  parameter int DW = 8,
  parameter int NE = 4
) (
  input  logic          clk,
  input  logic          load,
  input  logic          we,
  input  logic [1:0]    wsel,
  input  logic [DW-1:0] wdata,
  input  logic [1:0]    rsel,
  output logic [DW-1:0] rval,
  output logic          chg
);

  localparam logic [DW-1:0] CHG_MASK = DW'(8'h77);

  logic [DW-1:0] ent [NE];

  always_ff @(posedge clk) begin
    if (load) begin
      for (int e = 0; e < NE; e++) ent[e] <= DW'(dig_dflt(2'(e)));
    end else if (we) begin
      ent[wsel] <= wdata;
    end
  end

  assign chg  = |((ent[wsel] ^ wdata) & CHG_MASK);
  assign rval = ent[rsel];

endmodule

// File: rtl/pal_regfile.sv
module pal_regfile
  import pal_pkg::*;
#(
  parameter int BIG_N   = 256,
  parameter int SMALL_N = 16,
  parameter int DW      = 8,
  parameter int SW      = 4,
  localparam int NCOMP  = 3,
  localparam int BIG_AW = $clog2(BIG_N),
  localparam int SM_AW  = $clog2(SMALL_N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [1:0]    port_sel,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    mode,
  input  logic          init_req,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          redraw,
  output logic          busy
);

  logic              launch, last;
  logic [BIG_AW-1:0] seq_addr;

  pal_init_seq #(.DEPTH(BIG_N)) u_seq (
    .clk(clk), .rst(rst), .req(init_req),
    .busy(busy), .launch(launch), .last(last), .addr(seq_addr)
  );

  // mode decode, 256 over 16 over digital
  logic big_md, small_md, dig_md;
  assign big_md   = mode[1];
  assign small_md = mode[0] & ~mode[1];
  assign dig_md   = ~|mode;

  logic             cpu_go, is_idx;
  logic [NCOMP-1:0] comp_oh;
  assign cpu_go = wr_en & ~busy & ~launch;
  assign is_idx = (port_sel == PORT_INDEX);

  always_comb begin
    comp_oh = '0;
    case (port_sel)
      PORT_GRN: comp_oh = 3'b001;
      PORT_RED: comp_oh = 3'b010;
      PORT_BLU: comp_oh = 3'b100;
      default:  comp_oh = 3'b000;
    endcase
  end

  // palette number
  logic [DW-1:0] idx_q;
  always_ff @(posedge clk) begin
    if (rst) idx_q <= '0;
    else if (cpu_go & is_idx & ~dig_md) idx_q <= wr_data;
  end

  // packed digital palette
  logic [DW-1:0] dig_rval;
  logic          dig_chg;
  pal_digital #(.DW(DW)) u_dig (
    .clk(clk), .load(launch), .we(cpu_go & dig_md),
    .wsel(dig_entry(port_sel)), .wdata(wr_data),
    .rsel(dig_entry(port_sel)), .rval(dig_rval), .chg(dig_chg)
  );

  // default fill data
  logic [NCOMP*DW-1:0] big_fill;
  logic [NCOMP*SW-1:0] small_fill;
  for (genvar c = 0; c < NCOMP; c++) begin : g_fill
    assign big_fill[c*DW +: DW]   = DW'(big_dflt(8'(seq_addr), 2'(c)));
    assign small_fill[c*SW +: SW] = SW'(small_dflt(4'(seq_addr), 2'(c)));
  end

  // 256-entry store
  logic [NCOMP-1:0]    big_we;
  logic [BIG_AW-1:0]   big_wa;
  logic [NCOMP*DW-1:0] big_wd, big_q;
  assign big_we = busy ? {NCOMP{1'b1}}
                : ((cpu_go & big_md & ~is_idx) ? comp_oh : '0);
  assign big_wa = busy ? seq_addr : idx_q[BIG_AW-1:0];
  assign big_wd = busy ? big_fill : {NCOMP{wr_data}};

  pal_bank #(.DEPTH(BIG_N), .CW(DW), .NCOMP(NCOMP)) u_big (
    .clk(clk), .we(big_we), .waddr(big_wa), .wdata(big_wd),
    .raddr(idx_q[BIG_AW-1:0]), .rdata(big_q)
  );

  // 16-entry store
  logic [NCOMP-1:0]    sm_we;
  logic [SM_AW-1:0]    sm_wa;
  logic [NCOMP*SW-1:0] sm_wd, sm_q;
  assign sm_we = busy ? {NCOMP{seq_addr < BIG_AW'(SMALL_N)}}
               : ((cpu_go & small_md & ~is_idx) ? comp_oh : '0);
  assign sm_wa = busy ? seq_addr[SM_AW-1:0] : idx_q[SM_AW-1:0];
  assign sm_wd = busy ? small_fill : {NCOMP{wr_data[SW-1:0]}};

  pal_bank #(.DEPTH(SMALL_N), .CW(SW), .NCOMP(NCOMP)) u_small (
    .clk(clk), .we(sm_we), .waddr(sm_wa), .wdata(sm_wd),
    .raddr(idx_q[SM_AW-1:0]), .rdata(sm_q)
  );

  // redraw pulse
  always_ff @(posedge clk) begin
    if (rst) redraw <= 1'b0;
    else redraw <= last
                 | (cpu_go & ~is_idx & ~dig_md)
                 | (cpu_go & dig_md & dig_chg);
  end

  // read pipeline: stage 1 captures, stage 2 selects
  logic          rv1;
  logic [1:0]    sel1, mode1;
  logic [DW-1:0] idx1, dig1;
  always_ff @(posedge clk) begin
    if (rst) begin
      rv1 <= 1'b0;
    end else begin
      rv1 <= rd_en;
    end
    sel1  <= port_sel;
    mode1 <= mode;
    idx1  <= idx_q;
    dig1  <= dig_rval;
  end

  logic [DW-1:0] big_c;
  logic [SW-1:0] sm_c;
  always_comb begin
    case (sel1)
      PORT_RED: begin big_c = big_q[DW +: DW];   sm_c = sm_q[SW +: SW];   end
      PORT_BLU: begin big_c = big_q[2*DW +: DW]; sm_c = sm_q[2*SW +: SW]; end
      default:  begin big_c = big_q[0 +: DW];    sm_c = sm_q[0 +: SW];    end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rv1;
      if (rv1) begin
        if (sel1 == PORT_INDEX) rd_data <= (mode1 != 2'd0) ? idx1 : dig1;
        else if (mode1[1])      rd_data <= big_c;
        else if (mode1[0])      rd_data <= DW'(sm_c);
        else                    rd_data <= dig1;
      end
    end
  end

endmodule

// File: rtl/pal_regfile_chk.sv
module pal_regfile_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic       rd_en,
  input logic [1:0] port_sel,
  input logic [1:0] mode,
  input logic       init_req,
  input logic       rd_valid,
  input logic       redraw,
  input logic       busy
);

  // R1: redraw accompanies the end of a fill
  assert_fill_end_redraw_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> redraw);

  // R2: nothing signals a change while the fill runs
  assert_quiet_while_busy_R2: assert property (@(posedge clk) disable iff (rst)
    busy |-> !redraw);

  // R4: index writes in analog modes are silent
  assert_index_silent_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !busy && !init_req && port_sel == 2'd0 && mode != 2'd0) |=> !redraw);

  // R8: every accepted 256-entry colour write signals a change
  assert_big_write_redraw_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !busy && !init_req && port_sel != 2'd0 && mode[1]) |=> redraw);

  // R9: read latency of two cycles
  assert_read_latency_R9: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> ##1 rd_valid);

  assert_read_origin_R9: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_en, 2));

endmodule

bind pal_regfile pal_regfile_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .port_sel(port_sel),
  .mode(mode), .init_req(init_req), .rd_valid(rd_valid), .redraw(redraw),
  .busy(busy)
);

// File: tb/sim_pal_regfile.sv
module sim_pal_regfile;
  timeunit 1ns;
  timeprecision 1ps;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0, init_req = 1'b0;
  logic [1:0] port_sel = 2'd0, mode = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] rd_data;
  logic       rd_valid, redraw, busy;

  always #5 clk = ~clk;

  pal_regfile u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .port_sel(port_sel),
    .wr_data(wr_data), .mode(mode), .init_req(init_req), .rd_data(rd_data),
    .rd_valid(rd_valid), .redraw(redraw), .busy(busy)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_dig [4];
  int m_a16 [16][3];
  int m_a256[256][3];
  int m_idx, m_bcnt;
  int e_redraw, e_valid, e_data, p_valid, p_data;
  bit started = 0;

  int grb_words[16] = '{'h000, 'h007, 'h070, 'h077, 'h700, 'h707, 'h770, 'h777,
                        'h444, 'h00f, 'h0f0, 'h0ff, 'hf00, 'hf0f, 'hff0, 'hfff};
  int dig_init[4] = '{'h04, 'h15, 'h26, 'h37};

  function automatic int dmap(input int s);
    if (s == 0) return 3;
    if (s == 3) return 0;
    return s;
  endfunction

  task automatic load_defaults();
    for (int e = 0; e < 4; e++) m_dig[e] = dig_init[e];
    for (int e = 0; e < 16; e++) begin
      m_a16[e][0] = (grb_words[e] >> 8) & 15;
      m_a16[e][1] = (grb_words[e] >> 4) & 15;
      m_a16[e][2] = grb_words[e] & 15;
    end
    for (int i = 0; i < 256; i += 8) begin
      for (int c = 0; c < 3; c++) m_a256[i][c] = (i == 0) ? 0 : i - 4;
      for (int j = 1; j < 8; j++) begin
        m_a256[i+j][0] = ((j >> 2) & 1) ? i + 7 : 0;
        m_a256[i+j][1] = ((j >> 1) & 1) ? i + 7 : 0;
        m_a256[i+j][2] = (j & 1) ? i + 7 : 0;
      end
    end
  endtask

  function automatic int mval(input int s, input int md);
    if (s == 0) return (md != 0) ? m_idx : m_dig[3];
    if (md >= 2) return m_a256[m_idx][s-1];
    if (md == 1) return m_a16[m_idx % 16][s-1];
    return m_dig[dmap(s)];
  endfunction

  always @(posedge clk) begin
    int s, md, e;
    s  = int'(port_sel);
    md = int'(mode);
    e_valid = p_valid;
    if (p_valid != 0) e_data = p_data;
    p_valid = int'(rd_en);
    if (rd_en) p_data = mval(s, md);
    e_redraw = 0;
    if (rst) begin
      started = 1;
      load_defaults();
      m_idx = 0; m_bcnt = 256; p_valid = 0; e_valid = 0;
    end else if (m_bcnt > 0) begin
      m_bcnt--;
      if (m_bcnt == 0) e_redraw = 1;
    end else if (init_req) begin
      load_defaults();
      m_bcnt = 256;
    end else if (wr_en) begin
      if (s == 0 && md != 0) begin
        m_idx = int'(wr_data);
      end else if (md >= 2) begin
        m_a256[m_idx][s-1] = int'(wr_data);
        e_redraw = 1;
      end else if (md == 1) begin
        m_a16[m_idx % 16][s-1] = int'(wr_data) & 15;
        e_redraw = 1;
      end else begin
        e = dmap(s);
        if (((m_dig[e] ^ int'(wr_data)) & 'h77) != 0) e_redraw = 1;
        m_dig[e] = int'(wr_data);
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (started && !rst) begin
      check(busy == (m_bcnt > 0), "R1 busy (model)", int'(busy), int'(m_bcnt > 0));
      check(int'(redraw) == e_redraw, "R1/R2/R6/R7/R8 redraw (model)", int'(redraw), e_redraw);
      check(int'(rd_valid) == e_valid, "R9 rd_valid (model)", int'(rd_valid), e_valid);
      if (e_valid != 0)
        check(int'(rd_data) == e_data, "R9 rd_data (model)", int'(rd_data), e_data);
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; port_sel = s; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] s, input int exp, input string tag);
    @(negedge clk); rd_en = 1'b1; port_sel = s;
    @(negedge clk); rd_en = 1'b0;
    @(negedge clk);
    check(rd_valid == 1'b1, {tag, " valid"}, int'(rd_valid), 1);
    check(int'(rd_data) == exp, tag, int'(rd_data), exp);
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy) begin @(negedge clk); n++; end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(busy == 1'b1, "R1 busy after reset", int'(busy), 1);
    check(rd_valid == 1'b0, "R9 rd_valid after reset", int'(rd_valid), 0);
    wait_idle(n);
    check(n == 256, "R1 fill length", n, 256);
    check(redraw == 1'b1, "R1 redraw at fill end", int'(redraw), 1);

    // R10, R5: digital defaults through the port mapping
    mode = 2'd0;
    rd_chk(2'd0, 'h37, "R10 digital entry3");
    rd_chk(2'd1, 'h15, "R10 digital entry1");
    rd_chk(2'd2, 'h26, "R10 digital entry2");
    rd_chk(2'd3, 'h04, "R10 digital entry0");

    // R6: change mask
    wr(2'd3, 8'h84);
    check(redraw == 1'b0, "R6 bit7 only", int'(redraw), 0);
    rd_chk(2'd3, 'h84, "R5 full byte kept");
    wr(2'd3, 8'h8C);
    check(redraw == 1'b0, "R6 bit3 only", int'(redraw), 0);
    wr(2'd3, 8'h8D);
    check(redraw == 1'b1, "R6 bit0 change", int'(redraw), 1);
    wr(2'd3, 8'hCD);
    check(redraw == 1'b1, "R6 bit6 change", int'(redraw), 1);

    // R11, R4: 16-entry defaults and index port
    mode = 2'd1;
    wr(2'd0, 8'h09);
    check(redraw == 1'b0, "R4 index write silent", int'(redraw), 0);
    rd_chk(2'd1, 0,  "R11 entry9 green");
    rd_chk(2'd3, 15, "R11 entry9 blue");
    wr(2'd0, 8'h18);
    rd_chk(2'd0, 'h18, "R4 index readback");
    rd_chk(2'd2, 4, "R11 entry8 red");
    wr(2'd0, 8'h06);
    rd_chk(2'd1, 7, "R11 entry6 green");
    rd_chk(2'd3, 0, "R11 entry6 blue");

    // R7: nibble write
    wr(2'd1, 8'hA5);
    check(redraw == 1'b1, "R7 colour write redraw", int'(redraw), 1);
    rd_chk(2'd1, 'h05, "R7 low nibble stored");

    // R12: 256-entry defaults
    mode = 2'd2;
    wr(2'd0, 8'h09); rd_chk(2'd3, 'h0F, "R12 n=9 blue");
    rd_chk(2'd1, 0, "R12 n=9 green");
    wr(2'd0, 8'h08); rd_chk(2'd2, 4, "R12 n=8 grey");
    wr(2'd0, 8'h00); rd_chk(2'd1, 0, "R12 n=0 grey");
    wr(2'd0, 8'hFF); rd_chk(2'd2, 255, "R12 n=255 red");
    wr(2'd0, 8'hF8); rd_chk(2'd3, 244, "R12 n=248 grey");
    wr(2'd0, 8'h16); rd_chk(2'd1, 23, "R12 n=22 green");
    rd_chk(2'd3, 0, "R12 n=22 blue");

    // R8: byte write into separate store
    wr(2'd2, 8'h5A);
    check(redraw == 1'b1, "R8 colour write redraw", int'(redraw), 1);
    rd_chk(2'd2, 'h5A, "R8 byte stored");
    mode = 2'd1;
    rd_chk(2'd2, 7, "R8 16-entry store untouched");

    // R3: priority
    mode = 2'd3;
    rd_chk(2'd2, 'h5A, "R3 256 wins over 16");
    rd_chk(2'd0, 'h16, "R3 index port in analog");
    mode = 2'd0;
    rd_chk(2'd0, 'h37, "R3 digital when mode 0");

    // R2: writes ignored during a fill
    @(negedge clk); init_req = 1'b1;
    @(negedge clk); init_req = 1'b0;
    check(busy == 1'b1, "R1 init_req starts fill", int'(busy), 1);
    wr(2'd1, 8'hEE);
    check(redraw == 1'b0, "R2 no redraw while busy", int'(redraw), 0);
    wait_idle(n);
    rd_chk(2'd1, 'h15, "R2 busy write dropped");
    rd_chk(2'd3, 'h04, "R10 entry0 reloaded");
    mode = 2'd2;
    rd_chk(2'd2, 23, "R12 256 entry reloaded");

    // R9: read and write on the same edge
    mode = 2'd0;
    @(negedge clk); wr_en = 1'b1; rd_en = 1'b1; port_sel = 2'd1; wr_data = 8'h99;
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
    @(negedge clk);
    check(int'(rd_data) == 'h15, "R9 read sees old value", int'(rd_data), 'h15);
    rd_chk(2'd1, 'h99, "R9 write then visible");

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule